// File: doc/BRIEF.md
# Paged I2C EEPROM Transfer Sequencer

This block sits between a host and a byte-level I2C master. The host hands it one request: a flat 19-bit EEPROM memory address, a byte count, a direction and an optional cap on message length. The block turns that request into as many bus transactions as the device rules require. For each transaction it builds the device select byte from the top three address bits and sends the remaining sixteen bits as two offset bytes, high byte first. Write data is taken from a valid/ready byte stream and read data is returned on another valid/ready stream.

A write never crosses a 256-byte page. Each write transaction ends with a STOP, and the block then holds the bus idle for a programmable number of clock cycles while the device completes its internal write. A read runs sequentially across the whole remaining count unless the length cap splits it. The cap counts the two offset bytes, so each sub-transfer carries at most cap minus two data bytes. Any refused byte ends the transaction with a STOP and reports an error in place of a byte count.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: The select byte is binary 1010, then address bits 18:16, then the direction bit in bit 0 (0 = write, 1 = read). It is followed by offset byte address[15:8] and then offset byte address[7:0].
- R2: A write transaction issues START, select(write), both offset bytes, the data bytes in stream order, then STOP. Command codes on `cmd_op` are 0 = START, 1 = STOP, 2 = write byte, 3 = read byte.
- R3: A read transaction issues START, select(write), both offset bytes, a repeated START, select(read), one read command per byte, then STOP. `cmd_nack` is 1 only on the last read of the transaction. Each received byte appears on `rd_data` and is held until `rd_ready`.
- R4: The length of a write transaction is the smaller of the bytes left and 256 minus address[7:0].
- R5: Without a cap, a read is one transaction covering the whole count, whatever the page position.
- R6: After the STOP of every write transaction, no command is issued for at least WAIT_CYCLES clock cycles. This applies before the next START and before `done`.
- R7: When `max_len` is 3 or more, the request is cut into sub-transfers of at most `max_len`-2 data bytes, counted from the request start. For writes, R4 page splitting applies inside each sub-transfer.
- R8: A `max_len` of 1 or 2 makes the block pulse `error` without issuing any command.
- R9: Each transaction starts at the request address plus the bytes already moved, and the 19-bit address wraps.
- R10: A write command answered without an acknowledge is followed directly by STOP and an `error` pulse. No further commands are issued.
- R11: `busy` rises the cycle after a request is accepted and falls as `done` or `error` pulses. With `done`, `byte_count` equals the requested count.
- R12: A request with a zero count produces `done` with `byte_count` 0 and no commands.
- R13: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 19 | Flat EEPROM memory address |
| req_len | input | CNT_W | Byte count |
| req_read | input | 1 | 1 = read, 0 = write |
| max_len | input | CNT_W | Message length cap including offset bytes, 0 = none |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| byte_count | output | CNT_W | Data bytes moved |
| cmd_valid | output | 1 | Command to byte master valid |
| cmd_ready | input | 1 | Byte master accepts command |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_data | output | 8 | Byte to send |
| cmd_nack | output | 1 | Answer this read with a nack |
| rsp_valid | input | 1 | Byte command finished |
| rsp_ack | input | 1 | Acknowledge seen for a written byte |
| rsp_data | input | 8 | Byte received |
| wr_valid | input | 1 | Write data available |
| wr_ready | output | 1 | Write data taken |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data available |
| rd_ready | input | 1 | Read data taken |
| rd_data | output | 8 | Read data byte |

## Verification
The bench goes after start offsets just below a page edge, where a sequencer that ignores the page room would let a write run past byte 255 and wrap inside the page. It also covers caps small enough that a sub-transfer ends in the middle of a page; if sub-transfers were measured from the page instead of from the request start, the chunk lengths would differ. Reads that step across a device-select boundary show whether the select bits and the offsets stay paired. Refused bytes placed on the select, offset and data positions show whether a failure stops the traffic and reports an error rather than a count.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WR    = 2'd2,
    OP_RD    = 2'd3
  } i2c_op_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FAIL, ST_NEXT, ST_START, ST_SELW, ST_OFFH, ST_OFFL,
    ST_RSTART, ST_SELR, ST_DATA, ST_PUSH, ST_STOP, ST_WAIT
  } seq_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/seq_chunk_plan.sv
module seq_chunk_plan #(
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic [CNT_W-1:0]     rem,
  input  logic [CNT_W-1:0]     sub_rem,
  input  logic [PAGE_BITS-1:0] addr_lo,
  input  logic                 rd,
  input  logic                 cap_en,
  input  logic [CNT_W-1:0]     cap,
  output logic [CNT_W-1:0]     sub_new,
  output logic [CNT_W-1:0]     len
);
  localparam int PAGE = 1 << PAGE_BITS;
  int room;

  always_comb begin
    // a fresh sub-transfer starts only when the previous one is used up
    if (sub_rem != '0)            sub_new = sub_rem;
    else if (cap_en && cap < rem) sub_new = cap;
    else                          sub_new = rem;
    room = PAGE - int'(addr_lo);
    if (!rd && int'(sub_new) > room) len = CNT_W'(room);
    else                             len = sub_new;
  end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R6
  tmr_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(load));
  // R6
  tmr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> !expired);
endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
  import eeprom_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PAGE_BITS   = 8,
  parameter int WAIT_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [18:0]      req_addr,
  input  logic [CNT_W-1:0] req_len,
  input  logic             req_read,
  input  logic [CNT_W-1:0] max_len,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] byte_count,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nack,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  input  logic [7:0]       rsp_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);
  localparam int AW = 19;
  localparam int PAGE = 1 << PAGE_BITS;

  seq_state_t       st, nxt_plain;
  i2c_op_t          cur_op;
  logic [7:0]       cur_byte;
  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] rem, sub_rem, chunk_left, cap;
  logic [CNT_W-1:0] plan_sub, plan_len;
  logic             cap_en, rd_mode, issued, bad, tmr_go, tmr_exp;
  logic             issue_ok, needs_rsp;

  seq_chunk_plan #(.CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)) u_plan (
    .rem(rem), .sub_rem(sub_rem), .addr_lo(addr[PAGE_BITS-1:0]), .rd(rd_mode),
    .cap_en(cap_en), .cap(cap), .sub_new(plan_sub), .len(plan_len)
  );

  seq_wait_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_go), .expired(tmr_exp)
  );

  always_comb begin
    cur_op    = OP_STOP;
    cur_byte  = '0;
    nxt_plain = ST_IDLE;
    unique case (st)
      ST_START:  begin cur_op = OP_START; nxt_plain = ST_SELW; end
      ST_RSTART: begin cur_op = OP_START; nxt_plain = ST_SELR; end
      ST_SELW:   begin cur_op = OP_WR; cur_byte = {DEV_TYPE, addr[18:16], 1'b0}; nxt_plain = ST_OFFH; end
      ST_OFFH:   begin cur_op = OP_WR; cur_byte = addr[15:8]; nxt_plain = ST_OFFL; end
      ST_OFFL:   begin cur_op = OP_WR; cur_byte = addr[7:0]; nxt_plain = rd_mode ? ST_RSTART : ST_DATA; end
      ST_SELR:   begin cur_op = OP_WR; cur_byte = {DEV_TYPE, addr[18:16], 1'b1}; nxt_plain = ST_DATA; end
      ST_DATA:   begin cur_op = rd_mode ? OP_RD : OP_WR; cur_byte = wr_data; end
      ST_STOP:   begin cur_op = OP_STOP; nxt_plain = bad ? ST_FAIL : (rd_mode ? ST_NEXT : ST_WAIT); end
      default:   ;
    endcase
  end

  assign issue_ok  = !(st == ST_DATA && !rd_mode) || wr_valid;
  assign needs_rsp = (cur_op == OP_WR) || (cur_op == OP_RD);
  assign wr_ready  = (st == ST_DATA) && !rd_mode && !issued;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; done <= 1'b0; error <= 1'b0;
      byte_count <= '0; cmd_valid <= 1'b0; cmd_op <= OP_START;
      cmd_data <= '0; cmd_nack <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      addr <= '0; rem <= '0; sub_rem <= '0; chunk_left <= '0; cap <= '0;
      cap_en <= 1'b0; rd_mode <= 1'b0; issued <= 1'b0; bad <= 1'b0; tmr_go <= 1'b0;
    end else begin
      done   <= 1'b0;
      error  <= 1'b0;
      tmr_go <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          busy       <= 1'b1;
          addr       <= req_addr;
          rem        <= req_len;
          rd_mode    <= req_read;
          cap_en     <= (max_len != '0);
          cap        <= max_len - CNT_W'(2);
          sub_rem    <= '0;
          byte_count <= '0;
          bad        <= 1'b0;
          st <= (max_len != '0 && max_len <= CNT_W'(2)) ? ST_FAIL : ST_NEXT;
        end
        ST_FAIL: begin error <= 1'b1; busy <= 1'b0; st <= ST_IDLE; end
        ST_NEXT: begin
          if (rem == '0) begin
            done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else begin
            sub_rem    <= plan_sub;
            chunk_left <= plan_len;
            st         <= ST_START;
          end
        end
        ST_WAIT: if (tmr_exp) st <= ST_NEXT;
        ST_PUSH: if (rd_ready) begin
          rd_valid <= 1'b0;
          st <= (chunk_left == '0) ? ST_STOP : ST_DATA;
        end
        default: begin
          if (!issued) begin
            if (issue_ok) begin
              cmd_valid <= 1'b1;
              cmd_op    <= cur_op;
              cmd_data  <= cur_byte;
              cmd_nack  <= (st == ST_DATA) && rd_mode && (chunk_left == CNT_W'(1));
              issued    <= 1'b1;
            end
          end else if (cmd_valid) begin
            if (cmd_ready) begin
              cmd_valid <= 1'b0;
              if (!needs_rsp) begin
                issued <= 1'b0;
                st     <= nxt_plain;
                if (st == ST_STOP && !bad && !rd_mode) tmr_go <= 1'b1;
              end
            end
          end else if (rsp_valid) begin
            issued <= 1'b0;
            if (cur_op == OP_WR && !rsp_ack) begin
              bad <= 1'b1;
              st  <= ST_STOP;
            end else if (st == ST_DATA) begin
              addr       <= addr + 1'b1;
              rem        <= rem - 1'b1;
              sub_rem    <= sub_rem - 1'b1;
              chunk_left <= chunk_left - 1'b1;
              byte_count <= byte_count + 1'b1;
              if (rd_mode) begin
                rd_valid <= 1'b1;
                rd_data  <= rsp_data;
                st       <= ST_PUSH;
              end else begin
                st <= (chunk_left == CNT_W'(1)) ? ST_STOP : ST_DATA;
              end
            end else begin
              st <= nxt_plain;
            end
          end
        end
      endcase
    end
  end

  // R13
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R4
  page_room_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !rd_mode) |-> (int'(chunk_left) + int'(addr[PAGE_BITS-1:0]) <= PAGE));
  // R7
  cap_room_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && cap_en) |-> (sub_rem != '0 && sub_rem <= cap));
  // R11
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> (!busy && !(done && error)));
  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid);
  // R6
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !cmd_valid);
endmodule

// File: tb/tb_eeprom_xfer_seq.sv
module tb_eeprom_xfer_seq;
  localparam int CW    = 16;
  localparam int WAITC = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req_valid, req_read, busy, done, error;
  logic [18:0] req_addr;
  logic [CW-1:0] req_len, max_len, byte_count;
  logic cmd_valid, cmd_ready, cmd_nack, rsp_valid, rsp_ack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data, rsp_data, wr_data, rd_data;
  logic wr_valid, wr_ready, rd_valid, rd_ready;

  eeprom_xfer_seq #(.CNT_W(CW), .PAGE_BITS(8), .WAIT_CYCLES(WAITC)) dut (.*);

  int checks = 0, errs = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_op[0:4095], log_b[0:4095], log_nk[0:4095], log_t[0:4095], n_log;
  int exp_op[0:4095], exp_b[0:4095], exp_nk[0:4095], n_exp;
  logic [7:0] rd_got[0:1023];
  int n_rd, wr_idx, nak_idx, mdl_idx, t_end;
  bit wr_hs, rsp_due, got_done, got_err;
  logic [18:0] ptr;
  logic [7:0] due_data;
  bit due_ack;
  logic [CW-1:0] got_cnt;

  function automatic logic [7:0] mem_byte(input logic [18:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[18:16], 5'b10101};
  endfunction
  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 11 + 5) & 255);
  endfunction

  // byte-level master and EEPROM model, driven away from the active edge
  always @(negedge clk) begin
    if (wr_hs) wr_idx = wr_idx + 1;
    wr_data = src_byte(wr_idx);
    wr_hs = wr_valid && wr_ready;
    rd_ready = (cyc % 4) != 1;
    if (rd_valid && rd_ready) begin rd_got[n_rd] = rd_data; n_rd = n_rd + 1; end
    if (done) begin got_done = 1; got_cnt = byte_count; t_end = cyc; end
    if (error) begin got_err = 1; t_end = cyc; end
    if (rsp_due) begin
      rsp_valid = 1; rsp_ack = due_ack; rsp_data = due_data; rsp_due = 0;
    end else rsp_valid = 0;
    cmd_ready = (cyc % 3) != 0;
    if (cmd_valid && cmd_ready) begin
      log_op[n_log] = int'(cmd_op); log_t[n_log] = cyc;
      log_b[n_log] = (cmd_op == 2'd2) ? int'(cmd_data) : 0;
      log_nk[n_log] = (cmd_op == 2'd3) ? int'(cmd_nack) : 0;
      due_ack = (n_log != nak_idx);
      n_log = n_log + 1;
      if (cmd_op == 2'd0) mdl_idx = 0;
      if (cmd_op == 2'd2) begin
        if (mdl_idx == 0 && !cmd_data[0]) ptr[18:16] = cmd_data[3:1];
        if (mdl_idx == 1) ptr[15:8] = cmd_data;
        if (mdl_idx == 2) ptr[7:0] = cmd_data;
        mdl_idx = mdl_idx + 1;
        rsp_due = 1;
      end
      if (cmd_op == 2'd3) begin
        due_data = mem_byte(ptr); ptr = ptr + 1'b1; rsp_due = 1;
      end
    end
  end

  function automatic void pushx(input int op, input int b, input int nk);
    exp_op[n_exp] = op; exp_b[n_exp] = b; exp_nk[n_exp] = nk; n_exp = n_exp + 1;
  endfunction

  // expected command list from the requirements (R1, R2, R3, R4, R5, R7, R9)
  task automatic build_exp(input logic [18:0] a0, input int len, input bit rd, input int maxlen);
    int rem, cap, k, ps, room, n;
    logic [18:0] a;
    rem = len; a = a0; k = 0; n_exp = 0;
    cap = (maxlen == 0) ? (1 << 30) : maxlen - 2;
    while (rem > 0) begin
      ps = (rem < cap) ? rem : cap;
      while (ps > 0) begin
        room = 256 - int'(a[7:0]);
        n = rd ? ps : ((ps < room) ? ps : room);
        pushx(0, 0, 0);
        pushx(2, int'({4'hA, a[18:16], 1'b0}), 0);
        pushx(2, int'(a[15:8]), 0);
        pushx(2, int'(a[7:0]), 0);
        if (rd) begin
          pushx(0, 0, 0);
          pushx(2, int'({4'hA, a[18:16], 1'b1}), 0);
          for (int i = 0; i < n; i++) pushx(3, 0, (i == n - 1) ? 1 : 0);
        end else begin
          for (int i = 0; i < n; i++) pushx(2, int'(src_byte(k + i)), 0);
        end
        pushx(1, 0, 0);
        a = a + 19'(n); k += n; rem -= n; ps -= n;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic run_req(input logic [18:0] a, input int len, input bit rd,
                         input int maxlen, input int nak_at, input string tag);
    int bad_i, lim;
    bit exp_err, gap_ok, busy_seen;
    exp_err = (maxlen == 1 || maxlen == 2) || (nak_at >= 0);
    if (maxlen == 1 || maxlen == 2) n_exp = 0;
    else build_exp(a, len, rd, maxlen);
    if (nak_at >= 0) begin n_exp = nak_at + 1; pushx(1, 0, 0); end
    @(negedge clk);
    n_log = 0; n_rd = 0; wr_idx = 0; wr_hs = 0; nak_idx = nak_at;
    got_done = 0; got_err = 0; wr_data = src_byte(0);
    req_addr = a; req_len = CW'(len); req_read = rd; max_len = CW'(maxlen); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    busy_seen = busy;
    lim = 0;
    while (!got_done && !got_err && lim < 30000) begin @(negedge clk); lim++; end
    chk(busy_seen, "R11", "busy after accept", int'(busy_seen), 1);
    chk(lim < 30000, tag, "watchdog per request", lim, 0);
    chk(got_err == exp_err && got_done == !exp_err, tag, "error flag", int'(got_err), int'(exp_err));
    bad_i = -1;
    if (n_log == n_exp)
      for (int i = 0; i < n_log; i++)
        if (bad_i < 0 && (log_op[i] != exp_op[i] || log_b[i] != exp_b[i] || log_nk[i] != exp_nk[i])) bad_i = i;
    chk(n_log == n_exp, tag, "command count", n_log, n_exp);
    if (bad_i >= 0)
      chk(0, tag, "command entry op/byte", log_op[bad_i] * 256 + log_b[bad_i], exp_op[bad_i] * 256 + exp_b[bad_i]);
    else chk(1, tag, "command entries", 0, 0);
    if (!exp_err) begin
      chk(int'(got_cnt) == len, "R11", "byte_count", int'(got_cnt), len);
      if (rd) begin
        bad_i = -1;
        for (int i = 0; i < n_rd; i++) if (bad_i < 0 && rd_got[i] != mem_byte(a + 19'(i))) bad_i = i;
        chk(n_rd == len && bad_i < 0, "R9", "read data stream", n_rd, len);
      end else begin
        chk(wr_idx == len, "R2", "write bytes taken", wr_idx, len);
        gap_ok = 1;
        for (int i = 0; i + 1 < n_log; i++)
          if (log_op[i] == 1 && log_t[i + 1] - log_t[i] < WAITC) gap_ok = 0;
        if (n_log > 0 && t_end - log_t[n_log - 1] < WAITC) gap_ok = 0;
        chk(gap_ok, "R6", "write cycle wait", int'(gap_ok), 1);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_addr = '0; req_len = '0; req_read = 0; max_len = '0;
    cmd_ready = 0; rsp_valid = 0; rsp_ack = 1; rsp_data = '0; wr_valid = 1; wr_data = '0;
    rd_ready = 1; n_log = 0; n_rd = 0; wr_idx = 0; wr_hs = 0; rsp_due = 0; nak_idx = -1;
    mdl_idx = 0; ptr = '0; due_ack = 1; due_data = '0; got_done = 0; got_err = 0; t_end = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !error && !cmd_valid && !rd_valid, "R11", "reset state",
        int'({busy, done, error, cmd_valid, rd_valid}), 0);

    run_req(19'h6DA01, 300, 0, 0, -1, "R1");   // select bits 110, two pages
    run_req(19'h00100, 256, 0, 0, -1, "R4");   // one aligned full page
    run_req(19'h000FF, 3, 0, 0, -1, "R4");     // 1 then 2
    run_req(19'h3FFFE, 5, 1, 0, -1, "R5");     // read across select boundary
    run_req(19'h7FFFE, 4, 1, 0, -1, "R9");     // address wraps at 19 bits
    run_req(19'h12345, 10, 1, 6, -1, "R7");    // reads of 4,4,2
    run_req(19'h000C8, 200, 0, 102, -1, "R7"); // 56,44,100
    run_req(19'h000FE, 3, 0, 3, -1, "R7");     // one byte per transfer
    run_req(19'h00010, 8, 0, 2, -1, "R8");
    run_req(19'h00010, 8, 1, 1, -1, "R8");
    run_req(19'h00010, 0, 0, 0, -1, "R12");
    run_req(19'h00010, 0, 1, 9, -1, "R12");
    run_req(19'h00100, 4, 0, 0, 1, "R10");     // refused select
    run_req(19'h00100, 4, 1, 0, 2, "R10");     // refused offset
    run_req(19'h00100, 4, 1, 0, 5, "R10");     // refused read select
    run_req(19'h00100, 4, 0, 0, 5, "R10");     // refused data byte

    // sweeps near the page edge
    for (int lo = 250; lo < 256; lo++)
      for (int n = 1; n <= 10; n++) run_req({11'h2B3, 8'(lo)}, n, 0, 0, -1, "R4");
    for (int lo = 252; lo < 256; lo++)
      for (int n = 1; n <= 8; n++) run_req({11'h0A1, 8'(lo)}, n, 0, 5, -1, "R7");
    for (int lo = 250; lo < 256; lo++)
      for (int n = 1; n <= 6; n++) begin
        run_req({11'h4C2, 8'(lo)}, n, 1, 0, -1, "R3");
        run_req({11'h1F0, 8'(lo)}, n, 1, 5, -1, "R7");
      end
    // R13 is also guarded by cmd_hold_chk while cmd_ready stalls every third cycle
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule